// File: doc/BRIEF.md
# Interrupt Request Front End: NMI Edge Latch and IRQ Source Mask

This block sits between the interrupt pins of a CPU core and its instruction sequencer. It watches the non-maskable request level every clock cycle. When the level goes from low to high, it latches a need-service flag. A second register carries a copy of that flag, one update later, and the sequencer reads this copy at instruction boundaries. The acknowledge strobe from the sequencer clears the flag and its copy together.

Maskable requests come from several independent sources. Each source has its own set strobe and clear strobe, and they act only on that source's bit of a mask register. A polled pending bit is registered from that mask and the interrupt-disable flag. The poll-hold strobe arms a one-shot lock. The lock freezes the two sequencer-facing copies for one update, so a request that arrives late is deferred to the next boundary. The lock then disarms itself.

Top module: `irq_front_end`

## Requirements
- R1: On each rising clock edge where `nmi_level` is 1 and the level sampled on the previous edge was 0, `nmi_need` reads 1 after that edge. A level that stays high does not trigger again after an acknowledge.
- R2: `nmi_need` stays 1 until an edge where `nmi_ack` is 1. That edge clears both `nmi_need` and `nmi_seen`. If a new rising edge of the level is detected on the same edge as the acknowledge, `nmi_need` is 1 afterwards and `nmi_seen` is 0.
- R3: With no lock and no acknowledge, `nmi_seen` takes the value that `nmi_need` held before each edge. It therefore rises one edge after `nmi_need`.
- R4: `irq_src` bit i is set on an edge where `irq_set[i]` is 1 and cleared on an edge where only `irq_clr[i]` is 1. If both are 1 on the same edge, the set wins. Other bits are unaffected.
- R5: With no lock, `irq_poll` is loaded on each edge with (`irq_src` before the edge has any bit set) AND NOT `irq_disable`.
- R6: A `poll_hold` pulse on one edge arms a lock. On the next edge, `nmi_seen` and `irq_poll` keep their values (an acknowledge still clears `nmi_seen`). After that edge the lock is disarmed unless `poll_hold` was 1 again.
- R7: On an edge with `rst` at 1, `nmi_need`, `nmi_seen`, `irq_src`, `irq_poll`, the lock and the level history are all cleared. A level that is already high when reset is released counts as a fresh rising edge.
- R8: The number of sources is the parameter `NUM_SRC`, default 4, and every source bit behaves independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_level | input | 1 | Non-maskable request level |
| irq_set | input | NUM_SRC | Per-source set strobes |
| irq_clr | input | NUM_SRC | Per-source clear strobes |
| irq_disable | input | 1 | Interrupt-disable flag |
| poll_hold | input | 1 | Arms the one-update lock |
| nmi_ack | input | 1 | NMI serviced strobe |
| nmi_need | output | 1 | Latched NMI needed |
| nmi_seen | output | 1 | Copy of `nmi_need` delayed by one update |
| irq_src | output | NUM_SRC | Source mask |
| irq_poll | output | 1 | Polled IRQ-pending bit |

## Verification
Two events can fall on the same edge: the acknowledge, which clears the NMI latch, and a new rising edge of the request level, which sets it. The bench drops the level for one cycle and then raises it in the same cycle that it pulses `nmi_ack`. It then expects `nmi_need` to read 1 and `nmi_seen` to read 0, and `nmi_seen` to rise on the following edge. A similar collision happens when set and clear strobes hit the same source bit, and there the set must win. The bench also collides a lock with a fresh NMI edge and a fresh source bit, and checks that both copies rise one edge late.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
    typedef struct packed {
        logic nmi_seen;
        logic irq_poll;
    } poll_view_t;

    function automatic logic rise_seen(input logic prev_lvl, input logic cur_lvl);
        return cur_lvl & ~prev_lvl;
    endfunction
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch
    import irq_fe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_level,
    input  logic nmi_ack,
    output logic nmi_need
);
    logic prev_lvl_q;
    logic need_q;
    logic rise;

    assign rise = rise_seen(prev_lvl_q, nmi_level);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl_q <= 1'b0;
            need_q     <= 1'b0;
        end else begin
            prev_lvl_q <= nmi_level;
            if (rise)
                need_q <= 1'b1;
            else if (nmi_ack)
                need_q <= 1'b0;
        end
    end

    assign nmi_need = need_q;

    p_rise_sets_need_r1: assert property (@(posedge clk) disable iff (rst)
        (nmi_level && !prev_lvl_q) |=> nmi_need);
    p_need_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (nmi_need && !nmi_ack) |=> nmi_need);
    p_ack_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack && !(nmi_level && !prev_lvl_q)) |=> !nmi_need);
endmodule

// File: rtl/irq_src_mask.sv
module irq_src_mask #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_set,
    input  logic [NUM_SRC-1:0] irq_clr,
    output logic [NUM_SRC-1:0] irq_src
);
    logic [NUM_SRC-1:0] src_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                src_q[i] <= 1'b0;
            else if (irq_set[i])
                src_q[i] <= 1'b1;
            else if (irq_clr[i])
                src_q[i] <= 1'b0;
        end

        p_set_bit_r4: assert property (@(posedge clk) disable iff (rst)
            irq_set[i] |=> irq_src[i]);
        p_clr_bit_r4: assert property (@(posedge clk) disable iff (rst)
            (irq_clr[i] && !irq_set[i]) |=> !irq_src[i]);
        p_idle_bit_r8: assert property (@(posedge clk) disable iff (rst)
            (!irq_clr[i] && !irq_set[i]) |=> $stable(irq_src[i]));
    end

    assign irq_src = src_q;
endmodule

// File: rtl/poll_stage.sv
module poll_stage
    import irq_fe_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_need,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               irq_disable,
    input  logic               poll_hold,
    input  logic               nmi_ack,
    output poll_view_t         view
);
    logic       lock_q;
    poll_view_t view_q;
    poll_view_t view_d;

    always_comb begin
        view_d = view_q;
        if (!lock_q) begin
            view_d.nmi_seen = nmi_need;
            view_d.irq_poll = (|irq_src) & ~irq_disable;
        end
        if (nmi_ack)
            view_d.nmi_seen = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            view_q <= '0;
        end else begin
            lock_q <= poll_hold;
            view_q <= view_d;
        end
    end

    assign view = view_q;

    p_seen_delay_r3: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && !nmi_ack) |=> (view.nmi_seen == $past(nmi_need)));
    p_poll_value_r5: assert property (@(posedge clk) disable iff (rst)
        !lock_q |=> (view.irq_poll == ($past(|irq_src) && !$past(irq_disable))));
    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !nmi_ack) |=> ($stable(view.nmi_seen) && $stable(view.irq_poll)));
    p_lock_oneshot_r6: assert property (@(posedge clk) disable iff (rst)
        !poll_hold |=> !lock_q);
    p_ack_seen_r2: assert property (@(posedge clk) disable iff (rst)
        nmi_ack |=> !view.nmi_seen);
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
    import irq_fe_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_level,
    input  logic [NUM_SRC-1:0] irq_set,
    input  logic [NUM_SRC-1:0] irq_clr,
    input  logic               irq_disable,
    input  logic               poll_hold,
    input  logic               nmi_ack,
    output logic               nmi_need,
    output logic               nmi_seen,
    output logic [NUM_SRC-1:0] irq_src,
    output logic               irq_poll
);
    poll_view_t view;
    logic       need_w;
    logic [NUM_SRC-1:0] src_w;

    nmi_edge_latch u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_level (nmi_level),
        .nmi_ack   (nmi_ack),
        .nmi_need  (need_w)
    );

    irq_src_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .irq_set (irq_set),
        .irq_clr (irq_clr),
        .irq_src (src_w)
    );

    poll_stage #(.NUM_SRC(NUM_SRC)) u_poll (
        .clk         (clk),
        .rst         (rst),
        .nmi_need    (need_w),
        .irq_src     (src_w),
        .irq_disable (irq_disable),
        .poll_hold   (poll_hold),
        .nmi_ack     (nmi_ack),
        .view        (view)
    );

    assign nmi_need = need_w;
    assign nmi_seen = view.nmi_seen;
    assign irq_src  = src_w;
    assign irq_poll = view.irq_poll;

    p_reset_clears_r7: assert property (@(posedge clk)
        rst |=> (!nmi_need && !nmi_seen && !irq_poll && (irq_src == '0)));
endmodule

// File: tb/irq_front_end_tb_top.sv
module irq_front_end_tb_top;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          nmi_level;
    logic [NS-1:0] irq_set;
    logic [NS-1:0] irq_clr;
    logic          irq_disable;
    logic          poll_hold;
    logic          nmi_ack;
    logic          nmi_need;
    logic          nmi_seen;
    logic [NS-1:0] irq_src;
    logic          irq_poll;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_front_end #(.NUM_SRC(NS)) dut_i (
        .clk(clk), .rst(rst), .nmi_level(nmi_level), .irq_set(irq_set),
        .irq_clr(irq_clr), .irq_disable(irq_disable), .poll_hold(poll_hold),
        .nmi_ack(nmi_ack), .nmi_need(nmi_need), .nmi_seen(nmi_seen),
        .irq_src(irq_src), .irq_poll(irq_poll)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_set = '0; irq_clr = '0; poll_hold = 0; nmi_ack = 0;
    endtask

    task automatic t_reset();
        rst = 1; nmi_level = 0; irq_disable = 0; idle_inputs();
        tick(); tick();
        chk(nmi_need, 0, "R7 need after reset");
        chk(nmi_seen, 0, "R7 seen after reset");
        chk(irq_src, 0, "R7 src after reset");
        chk(irq_poll, 0, "R7 poll after reset");
        rst = 0;
    endtask

    task automatic t_nmi_basic();
        nmi_level = 1; tick();
        chk(nmi_need, 1, "R1 need after rise");
        chk(nmi_seen, 0, "R3 seen not yet");
        tick();
        chk(nmi_seen, 1, "R3 seen one edge later");
        chk(nmi_need, 1, "R2 need sticky");
        nmi_ack = 1; tick(); nmi_ack = 0;
        chk(nmi_need, 0, "R2 ack clears need");
        chk(nmi_seen, 0, "R2 ack clears seen");
        tick(); tick();
        chk(nmi_need, 0, "R1 steady high no retrigger");
        nmi_level = 0; tick();
        nmi_level = 1; tick();
        chk(nmi_need, 1, "R1 second rise");
        nmi_ack = 1; tick(); nmi_ack = 0;
    endtask

    task automatic t_ack_collide();
        nmi_level = 0; tick();
        nmi_level = 1; tick(); tick();
        chk(nmi_seen, 1, "R3 setup seen");
        nmi_level = 0; tick();
        nmi_level = 1; nmi_ack = 1; tick(); nmi_ack = 0;
        chk(nmi_need, 1, "R2 rise wins over ack");
        chk(nmi_seen, 0, "R2 ack clears seen on collide");
        tick();
        chk(nmi_seen, 1, "R3 seen after collide");
        nmi_ack = 1; tick(); nmi_ack = 0;
    endtask

    task automatic t_irq_mask();
        irq_set = 4'b0100; tick(); irq_set = '0;
        chk(irq_src, 4, "R4 set bit2");
        chk(irq_poll, 0, "R5 poll one edge late");
        tick();
        chk(irq_poll, 1, "R5 poll pending");
        irq_disable = 1; tick();
        chk(irq_poll, 0, "R5 disabled masks poll");
        irq_disable = 0;
        irq_clr = 4'b1100; irq_set = 4'b1010; tick(); idle_inputs();
        chk(irq_src, 10, "R4 set wins and per-bit clear");
        irq_set = 4'b0001; tick(); idle_inputs();
        chk(irq_src, 11, "R8 independent bit0");
        irq_clr = 4'b1111; tick(); idle_inputs();
        chk(irq_src, 0, "R4 clear all");
        chk(irq_poll, 1, "R5 poll uses prior mask");
        tick();
        chk(irq_poll, 0, "R5 poll drops");
    endtask

    task automatic t_lock();
        nmi_level = 0; tick();
        nmi_level = 1; irq_set = 4'b0001; poll_hold = 1; tick(); idle_inputs();
        chk(nmi_need, 1, "R1 need with lock armed");
        chk(irq_src, 1, "R4 src with lock armed");
        tick();
        chk(nmi_seen, 0, "R6 lock holds seen");
        chk(irq_poll, 0, "R6 lock holds poll");
        tick();
        chk(nmi_seen, 1, "R6 lock released seen");
        chk(irq_poll, 1, "R6 lock released poll");
        nmi_ack = 1; irq_clr = 4'b0001; tick(); idle_inputs(); tick();
    endtask

    task automatic t_reset_high();
        nmi_level = 1; irq_set = 4'b0010;
        tick(); tick(); idle_inputs();
        rst = 1; tick();
        chk(nmi_need, 0, "R7 reset clears need");
        chk(irq_src, 0, "R7 reset clears src");
        chk(irq_poll, 0, "R7 reset clears poll");
        rst = 0; tick();
        chk(nmi_need, 1, "R7 high level after reset is rise");
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_nmi_basic();
        t_ack_collide();
        t_irq_mask();
        t_lock();
        t_reset_high();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule